// File: doc/BRIEF.md
# ISA-Style Bus Cycle Sequencer

This block turns internal transfer requests into memory or I/O cycles on an ISA-like external bus. A request gives an address, a byte or word size, a direction, a memory or I/O space selection, write data, and the timing for that access. The timing fields are the number of programmed wait states, how many extra states the ready line may add, whether the command is delayed by one clock, and whether the 16-bit acknowledge is forced. The sequencer sends the address with a one-clock active-low address-latch strobe. It then asserts exactly one of the four active-low commands for the programmed width. It stretches that command while the target holds the open-collector ready line low, within a programmed limit.

For a word request, the sequencer samples the target's active-low 16-bit acknowledge while the address is out. If the acknowledge is absent and not forced, the word runs as two byte cycles. The low byte goes first at the even address. The high byte follows at the odd address on the low data lanes. A read is reassembled before a single completion pulse. All bus outputs come straight from flops, and a new request is taken only while the sequencer is idle.

Top module: `isa_cycle_seq`

## Requirements
- R1: While reset is held and on the clock after it ends, all four commands, the address strobe and the byte-high enable are high, the data drivers are off, `done` is low and `req_ready` is high.
- R2: The address strobe `ale_n` is low for exactly one clock at the start of every bus cycle, which includes each half of a split word, and no command is low in that clock.
- R3: During a command, exactly one strobe is low: `memr_n` for a memory read, `memw_n` for a memory write, `ior_n` for an I/O read, `iow_n` for an I/O write.
- R4: With ready high, the command stays low for 1 + `req_waits` clocks, where `req_waits` ranges from 0 to 7.
- R5: Ready is looked at only after the programmed waits. The command ends on the first clock in which `rdy` is high. If ready stays low, the command is stretched by at most `req_xrdy` clocks, where `req_xrdy` ranges from 0 to 2.
- R6: From the address-strobe clock to the first command clock there is 1 clock when `req_dly`=0 and 2 clocks when `req_dly`=1.
- R7: For a write, `sd_oe` is high from the address-strobe clock onward and the write data is already on `sd_out` in the first command clock. For a read, `sd_oe` stays low.
- R8: The pair (`bhe_n`, `bus_addr[0]`) during the cycle is (0,0) for a word, (1,0) for a byte at an even address and (0,1) for a byte at an odd address. (1,1) never appears. Word requests use even addresses.
- R9: A word request whose target drives `cs16_n` low in the address clock, or that has `req_force16` set, runs as one 16-bit cycle. `rdata` then returns `sd_in` unchanged.
- R10: Otherwise a word request runs as two cycles. The first is at the even address with the low byte on `sd_out[7:0]`. The second is at address+1 with `bhe_n`=0 and the high byte on `sd_out[7:0]`. A read returns {second `sd_in[7:0]`, first `sd_in[7:0]`}.
- R11: `done` pulses for one clock in the last clock of the access. With no waits and no delay, this is the third clock counted from the address strobe.
- R12: A byte read returns its lane (`sd_in[7:0]` for even, `sd_in[15:8]` for odd) in `rdata[7:0]` with `rdata[15:8]`=0. A byte write drives its byte on both halves of `sd_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request taken this clock |
| req_addr | input | ADDR_W | Byte address |
| req_word | input | 1 | 1 = 16-bit request, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_force16 | input | 1 | Treat the target as 16-bit |
| req_dly | input | 1 | Add one clock of address setup before the command |
| req_waits | input | 3 | Programmed wait states |
| req_xrdy | input | 2 | Maximum ready-extension states |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result, valid with done |
| bus_addr | output | ADDR_W | Bus address |
| ale_n | output | 1 | Address-latch strobe, active low |
| bhe_n | output | 1 | Byte-high enable, active low |
| memr_n | output | 1 | Memory read command |
| memw_n | output | 1 | Memory write command |
| ior_n | output | 1 | I/O read command |
| iow_n | output | 1 | I/O write command |
| sd_out | output | 16 | Data driven to the bus |
| sd_oe | output | 1 | Data driver enable |
| sd_in | input | 16 | Data from the bus |
| cs16_n | input | 1 | Target 16-bit acknowledge, active low |
| rdy | input | 1 | Open-collector ready, low inserts waits |

## Verification
The assertions rely on three input rules. Word requests arrive only with an even address. A request is offered only while `req_ready` is high. `cs16_n` and `rdy` hold steady through each clock edge. The stimulus respects these rules in three ways. Every task issues a single request from idle, with word addresses ending in an even digit. The bench changes `rdy`, `sd_in` and `cs16_n` only at falling edges. It drives ready low according to how many command clocks it has already counted, which gives a chosen extension against each programmed limit.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_DLY,
    S_CMD,
    S_RECOV
  } seq_state_t;

  typedef struct packed {
    logic       word;
    logic       write;
    logic       mem;
    logic       force16;
    logic       dly;
    logic [2:0] waits;
    logic [1:0] xrdy;
  } req_ctl_t;
endpackage

// File: rtl/isa_wait_ctr.sv
module isa_wait_ctr #(
  parameter int WAIT_W = 3,
  parameter int XRDY_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [WAIT_W-1:0] waits,
  input  logic [XRDY_W-1:0] xrdy,
  input  logic              rdy,
  output logic              end_now
);
  localparam int CW = ((WAIT_W > XRDY_W) ? WAIT_W : XRDY_W) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          waits_over;

  assign lim        = CW'(waits) + CW'(xrdy);
  assign waits_over = (cnt >= CW'(waits));
  assign end_now    = active && waits_over && (rdy || (cnt >= lim));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt <= '0;
    end else if (!end_now) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: the command clock count never passes waits plus the ready allowance
  assert_wait_bound_R5: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= lim));
endmodule

// File: rtl/isa_lane_mux.sv
module isa_lane_mux #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              word,
  input  logic              half,
  input  logic [15:0]       wdata,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bhe_n_o,
  output logic [15:0]       wdata_o
);
  always_comb begin
    if (word) begin
      addr_o  = {base[ADDR_W-1:1], half};
      bhe_n_o = 1'b0;
      wdata_o = half ? {wdata[15:8], wdata[15:8]} : wdata;
    end else begin
      addr_o  = base;
      bhe_n_o = ~base[0];
      wdata_o = {wdata[7:0], wdata[7:0]};
    end
  end
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_force16,
  input  logic              req_dly,
  input  logic [2:0]        req_waits,
  input  logic [1:0]        req_xrdy,
  input  logic [15:0]       req_wdata,
  output logic              done,
  output logic [15:0]       rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              ale_n,
  output logic              bhe_n,
  output logic              memr_n,
  output logic              memw_n,
  output logic              ior_n,
  output logic              iow_n,
  output logic [15:0]       sd_out,
  output logic              sd_oe,
  input  logic [15:0]       sd_in,
  input  logic              cs16_n,
  input  logic              rdy
);
  seq_state_t        st, st_n;
  logic              half, half_n;
  logic              split, split_n;
  logic [ADDR_W-1:0] base, base_n;
  req_ctl_t          ctl, ctl_n;
  logic [15:0]       wd, wd_n;
  logic              end_now;
  logic              final_n;
  logic              cmd_on;
  logic [ADDR_W-1:0] mux_addr;
  logic              mux_bhe_n;
  logic [15:0]       mux_wdata;

  isa_wait_ctr #(.WAIT_W(3), .XRDY_W(2)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .active  (st == S_CMD),
    .waits   (ctl.waits),
    .xrdy    (ctl.xrdy),
    .rdy     (rdy),
    .end_now (end_now)
  );

  always_comb begin
    st_n    = st;
    half_n  = half;
    split_n = split;
    base_n  = base;
    ctl_n   = ctl;
    wd_n    = wd;
    case (st)
      S_IDLE: if (req_valid) begin
        st_n    = S_ADDR;
        half_n  = 1'b0;
        split_n = 1'b0;
        base_n  = req_addr;
        wd_n    = req_wdata;
        ctl_n   = '{word: req_word, write: req_write, mem: req_mem,
                    force16: req_force16, dly: req_dly,
                    waits: req_waits, xrdy: req_xrdy};
      end
      S_ADDR: begin
        st_n = ctl.dly ? S_DLY : S_CMD;
        if (!half && ctl.word) split_n = cs16_n && !ctl.force16;
      end
      S_DLY:  st_n = S_CMD;
      S_CMD:  if (end_now) st_n = S_RECOV;
      S_RECOV: begin
        if (split && !half) begin
          st_n   = S_ADDR;
          half_n = 1'b1;
        end else begin
          st_n = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  assign final_n = !(split_n && !half_n);
  assign cmd_on  = (st_n == S_CMD);

  isa_lane_mux #(.ADDR_W(ADDR_W)) u_lane (
    .base    (base_n),
    .word    (ctl_n.word),
    .half    (half_n),
    .wdata   (wd_n),
    .addr_o  (mux_addr),
    .bhe_n_o (mux_bhe_n),
    .wdata_o (mux_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      half      <= 1'b0;
      split     <= 1'b0;
      base      <= '0;
      ctl       <= '0;
      wd        <= '0;
      req_ready <= 1'b1;
      done      <= 1'b0;
      rdata     <= '0;
      bus_addr  <= '0;
      ale_n     <= 1'b1;
      bhe_n     <= 1'b1;
      memr_n    <= 1'b1;
      memw_n    <= 1'b1;
      ior_n     <= 1'b1;
      iow_n     <= 1'b1;
      sd_out    <= '0;
      sd_oe     <= 1'b0;
    end else begin
      st        <= st_n;
      half      <= half_n;
      split     <= split_n;
      base      <= base_n;
      ctl       <= ctl_n;
      wd        <= wd_n;
      req_ready <= (st_n == S_IDLE);
      done      <= (st_n == S_RECOV) && final_n;
      ale_n     <= !(st_n == S_ADDR);
      memr_n    <= !(cmd_on &&  ctl_n.mem && !ctl_n.write);
      memw_n    <= !(cmd_on &&  ctl_n.mem &&  ctl_n.write);
      ior_n     <= !(cmd_on && !ctl_n.mem && !ctl_n.write);
      iow_n     <= !(cmd_on && !ctl_n.mem &&  ctl_n.write);
      if (st_n != S_IDLE) begin
        bus_addr <= mux_addr;
        bhe_n    <= mux_bhe_n;
        sd_out   <= mux_wdata;
      end else begin
        bhe_n    <= 1'b1;
      end
      sd_oe <= (st_n != S_IDLE) && ctl_n.write;
      if (st == S_CMD && end_now && !ctl.write) begin
        if (!ctl.word)
          rdata <= {8'h00, base[0] ? sd_in[15:8] : sd_in[7:0]};
        else if (!split)
          rdata <= sd_in;
        else if (!half)
          rdata[7:0] <= sd_in[7:0];
        else
          rdata[15:8] <= sd_in[7:0];
      end
    end
  end

  // R3: never more than one command strobe low
  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~memr_n, ~memw_n, ~ior_n, ~iow_n}));

  // R2: strobe lasts a single clock
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
    !ale_n |=> ale_n);

  // R2: no command overlaps the address strobe
  assert_ale_no_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    !ale_n |-> (memr_n && memw_n && ior_n && iow_n));

  // R8: illegal byte-enable pair never shown
  assert_bhe_legal_R8: assert property (@(posedge clk) disable iff (rst)
    !ale_n |-> !(bhe_n && bus_addr[0]));

  // R8: word requests arrive at even addresses
  assert_word_even_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_word) |-> !req_addr[0]);

  // R7: data drivers never fight a read command
  assert_oe_read_R7: assert property (@(posedge clk) disable iff (rst)
    sd_oe |-> (memr_n && ior_n));

  // R11: completion is a single-clock pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/isa_cycle_seq_test.sv
module isa_cycle_seq_test;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_word = 1'b0;
  logic              req_write = 1'b0;
  logic              req_mem = 1'b0;
  logic              req_force16 = 1'b0;
  logic              req_dly = 1'b0;
  logic [2:0]        req_waits = '0;
  logic [1:0]        req_xrdy = '0;
  logic [15:0]       req_wdata = '0;
  logic              done;
  logic [15:0]       rdata;
  logic [ADDR_W-1:0] bus_addr;
  logic              ale_n, bhe_n, memr_n, memw_n, ior_n, iow_n;
  logic [15:0]       sd_out;
  logic              sd_oe;
  logic [15:0]       sd_in = '0;
  logic              cs16_n = 1'b1;
  logic              rdy = 1'b1;

  int n_checks = 0;
  int n_fails  = 0;

  // per-access observations, index = half
  int              n_ale;
  int              ale_t [2];
  logic [ADDR_W-1:0] a_addr [2];
  logic            a_bhe [2];
  logic            a_oe [2];
  int              first_t [2];
  int              clen [2];
  logic [15:0]     wout [2];
  logic            w_oe [2];
  int              done_t;
  logic [15:0]     got_rdata;
  int              bad_cmd;
  int              read_oe;

  always #2 clk = ~clk;

  isa_cycle_seq #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_mem(req_mem), .req_force16(req_force16), .req_dly(req_dly),
    .req_waits(req_waits), .req_xrdy(req_xrdy), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_addr(bus_addr), .ale_n(ale_n),
    .bhe_n(bhe_n), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
    .iow_n(iow_n), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in),
    .cs16_n(cs16_n), .rdy(rdy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic [ADDR_W-1:0] addr, input bit word, input bit wr,
                            input bit mem, input bit f16, input bit dly,
                            input int waits, input int xrdy, input logic [15:0] wdata,
                            input bit cs16, input int stall,
                            input logic [15:0] rd0, input logic [15:0] rd1);
    logic [3:0] exp_k;
    logic [3:0] act_k;
    int hc;
    exp_k = {mem && !wr, mem && wr, !mem && !wr, !mem && wr};
    n_ale = 0; done_t = -1; bad_cmd = 0; read_oe = 0;
    for (int i = 0; i < 2; i++) begin
      clen[i] = 0; first_t[i] = -1; ale_t[i] = -1;
    end
    @(negedge clk);
    req_addr = addr; req_word = word; req_write = wr; req_mem = mem;
    req_force16 = f16; req_dly = dly; req_waits = 3'(waits); req_xrdy = 2'(xrdy);
    req_wdata = wdata; cs16_n = cs16; rdy = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 200; t++) begin
      if (!ale_n) begin
        if (n_ale < 2) begin
          ale_t[n_ale] = t; a_addr[n_ale] = bus_addr;
          a_bhe[n_ale] = bhe_n; a_oe[n_ale] = sd_oe;
        end
        n_ale++;
      end
      hc = (n_ale > 0) ? ((n_ale > 2) ? 1 : n_ale - 1) : 0;
      act_k = {~memr_n, ~memw_n, ~ior_n, ~iow_n};
      if (!wr && sd_oe) read_oe++;
      if (act_k != 4'b0 && act_k != exp_k) bad_cmd++;
      if (act_k == exp_k) begin
        if (clen[hc] == 0) begin
          first_t[hc] = t; wout[hc] = sd_out; w_oe[hc] = sd_oe;
        end
        clen[hc]++;
        sd_in = (hc == 1) ? rd1 : rd0;
        rdy = (clen[hc] >= waits + 1 + stall);
      end else begin
        rdy = 1'b1;
      end
      if (done) begin
        done_t = t; got_rdata = rdata;
        break;
      end
      @(negedge clk);
    end
    rdy = 1'b1;
    chk(done_t >= 0, "R11 access completes", done_t, 0);
    chk(bad_cmd == 0, "R3 only the selected command strobes", bad_cmd, 0);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R11 done single pulse, idle after", {done, req_ready}, 2'b01);
  endtask

  task automatic t_reset;
    chk({ale_n, bhe_n, memr_n, memw_n, ior_n, iow_n} == 6'h3f, "R1 strobes high at reset",
        {ale_n, bhe_n, memr_n, memw_n, ior_n, iow_n}, 6'h3f);
    chk(!sd_oe && !done && req_ready, "R1 oe/done/ready at reset", {sd_oe, done, req_ready}, 3'b001);
  endtask

  task automatic t_io_byte_read_fast;
    run_access(24'h000310, 0, 0, 0, 0, 0, 0, 2, 16'h0, 1, 0, 16'h5AA5, 16'h0);
    chk(n_ale == 1, "R2 one strobe for byte", n_ale, 1);
    chk(done_t - ale_t[0] == 2, "R11 three-clock fastest I/O", done_t - ale_t[0], 2);
    chk({a_bhe[0], a_addr[0][0]} == 2'b10, "R8 even byte encoding", {a_bhe[0], a_addr[0][0]}, 2'b10);
    chk(got_rdata == 16'h00A5, "R12 even byte read lane", got_rdata, 16'h00A5);
    chk(read_oe == 0, "R7 no drive on read", read_oe, 0);
  endtask

  task automatic t_mem_word_write;
    run_access(24'h004000, 1, 1, 1, 0, 0, 3, 2, 16'h1234, 0, 0, 16'h0, 16'h0);
    chk(n_ale == 1, "R9 acknowledged word is one cycle", n_ale, 1);
    chk(clen[0] == 4, "R4 width 1+3", clen[0], 4);
    chk({a_bhe[0], a_addr[0][0]} == 2'b00, "R8 word encoding", {a_bhe[0], a_addr[0][0]}, 2'b00);
    chk(a_oe[0] && w_oe[0] && wout[0] == 16'h1234, "R7 write data before command", wout[0], 16'h1234);
    chk(first_t[0] - ale_t[0] == 1, "R6 setup without delay", first_t[0] - ale_t[0], 1);
  endtask

  task automatic t_io_odd_byte_delay;
    run_access(24'h000371, 0, 1, 0, 0, 1, 1, 0, 16'h00C3, 1, 0, 16'h0, 16'h0);
    chk(first_t[0] - ale_t[0] == 2, "R6 setup with delay", first_t[0] - ale_t[0], 2);
    chk({a_bhe[0], a_addr[0][0]} == 2'b01, "R8 odd byte encoding", {a_bhe[0], a_addr[0][0]}, 2'b01);
    chk(wout[0] == 16'hC3C3, "R12 byte replicated on lanes", wout[0], 16'hC3C3);
    chk(clen[0] == 2, "R4 width 1+1", clen[0], 2);
  endtask

  task automatic t_ready_extend;
    run_access(24'h008000, 1, 0, 1, 0, 0, 2, 2, 16'h0, 0, 1, 16'hBEEF, 16'h0);
    chk(clen[0] == 4, "R5 one ready extension", clen[0], 4);
    chk(got_rdata == 16'hBEEF, "R9 word read data", got_rdata, 16'hBEEF);
  endtask

  task automatic t_ready_cap;
    run_access(24'h008002, 1, 0, 1, 0, 0, 1, 2, 16'h0, 0, 5, 16'h0F0F, 16'h0);
    chk(clen[0] == 4, "R5 extension capped at 2", clen[0], 4);
    run_access(24'h008004, 1, 0, 1, 0, 0, 1, 0, 16'h0, 0, 5, 16'h0F0F, 16'h0);
    chk(clen[0] == 2, "R5 no extension when limit 0", clen[0], 2);
  endtask

  task automatic t_split_read;
    run_access(24'h00A010, 1, 0, 1, 0, 0, 0, 2, 16'h0, 1, 0, 16'hEE11, 16'hDD22);
    chk(n_ale == 2, "R2 R10 two strobes for split", n_ale, 2);
    chk(a_addr[0] == 24'h00A010 && a_addr[1] == 24'h00A011, "R10 half addresses", a_addr[1], 24'h00A011);
    chk({a_bhe[1], a_addr[1][0]} == 2'b01, "R10 second half encoding", {a_bhe[1], a_addr[1][0]}, 2'b01);
    chk(got_rdata == 16'h2211, "R10 reassembled read", got_rdata, 16'h2211);
  endtask

  task automatic t_split_write;
    run_access(24'h000200, 1, 1, 0, 0, 0, 0, 2, 16'hAB34, 1, 0, 16'h0, 16'h0);
    chk(n_ale == 2, "R10 split write two cycles", n_ale, 2);
    chk(wout[0][7:0] == 8'h34, "R10 low byte first", wout[0][7:0], 8'h34);
    chk(wout[1][7:0] == 8'hAB, "R10 high byte on low lanes", wout[1][7:0], 8'hAB);
  endtask

  task automatic t_force16;
    run_access(24'h00C000, 1, 0, 1, 1, 0, 7, 0, 16'h0, 1, 0, 16'h7788, 16'h0);
    chk(n_ale == 1, "R9 forced 16-bit single cycle", n_ale, 1);
    chk(clen[0] == 8, "R4 width 1+7", clen[0], 8);
    chk(got_rdata == 16'h7788, "R9 forced word data", got_rdata, 16'h7788);
  endtask

  initial begin
    #(4 * 100000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_io_byte_read_fast();
    t_mem_word_write();
    t_io_odd_byte_delay();
    t_ready_extend();
    t_ready_cap();
    t_split_read();
    t_split_write();
    t_force16();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule